// File: doc/BRIEF.md
# Aperture Remapping Address Translator

This block sits between a bus master and memory. It turns bus addresses that fall inside a remapping window into 40-bit physical addresses, one 4 KB page at a time, by reading 32-bit translation entries held in a small internal table. Addresses outside the window, or any address while the window is off, go through unchanged.

Software programs the window through two configuration inputs: a base field, which places the window on a 32 MB boundary, and a control field, which turns translation on and picks the window size. Table entries are written through a separate write port. A lookup is a request/response exchange. A one-entry cache keeps the most recent entry. A flush pulse clears that cache, which makes a rewritten entry visible.

Top module: `apt_translator`

## Requirements
- R1: After reset, `lk_ready` is 1, `lk_done` is 0 and the translation cache is empty, so the first in-window lookup reads the table.
- R2: The window starts at `cfg_base` multiplied by 2^25. Its size is 32 MB shifted left by `cfg_ctrl[3:1]`. A bus address is inside the window when base <= address < base + size.
- R3: When `cfg_ctrl[0]` is 0, or the address is outside the window, the lookup returns status 0 (pass). `lk_paddr` is then the bus address zero-extended to 40 bits.
- R4: The window is off, and every lookup passes through, when base + size is at least 0xFFFFFFFF or when the size is zero.
- R5: The entry index is (address - base) >> 12. In an entry, bits 31:12 hold physical address bits 31:12 and bits 11:4 hold physical address bits 39:32. When bit 0 of the entry is 1, the lookup returns status 1 (translated), with the decoded page address plus the low 12 bits of the bus address.
- R6: An in-window lookup returns status 2 (fault) and `lk_paddr` = 0 in two cases: the entry's bit 0 is 0, or the index is at or beyond the table depth.
- R7: `lk_done` is a one-cycle pulse. It comes one cycle after the accepting edge for a pass, an out-of-table fault or a cache hit, and two cycles after it when the table must be read.
- R8: A lookup to the page held in the cache uses the cached entry, even if that table slot has been rewritten since the entry was cached.
- R9: A flush while idle empties the cache at once. A flush that arrives while a lookup is in flight lets that lookup finish with the entry it was using, and empties the cache when that lookup completes.
- R10: A request is accepted only while `lk_ready` is 1. A request presented while a lookup is in flight is ignored and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base_we | input | 1 | Load the window base field |
| cfg_base | input | 15 | Window base in 32 MB units |
| cfg_ctrl_we | input | 1 | Load the control field |
| cfg_ctrl | input | 4 | Bit 0 enables translation; bits 3:1 set the size order |
| tbl_we | input | 1 | Write one table entry |
| tbl_idx | input | 6 | Table slot to write |
| tbl_wdata | input | 32 | Entry value to write |
| flush | input | 1 | Invalidate the cached entry |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | Bus address to translate |
| lk_ready | output | 1 | Block can accept a request |
| lk_done | output | 1 | Result valid pulse |
| lk_status | output | 2 | 0 pass, 1 translated, 2 fault |
| lk_paddr | output | 40 | Resulting physical address |

## Verification
The assertions check four things on every cycle. Each result is well formed: a pass echoes the captured address, a fault carries a zero address, and a translation keeps the page offset. Every response is a single pulse. The block drops `lk_ready` after it accepts a request. An idle flush leaves the cache empty on the next cycle. Other behaviour needs the bench's scenarios because it shows only through latency or through the history of table writes and flushes: the window bounds for each size order, the overflow rule that turns the window off, hits on a stale entry, and a flush deferred until an in-flight lookup completes.

// File: rtl/apt_pkg.sv
// Shared widths, result type and entry decoding for the aperture translator.
// Assumes 4 KB pages, 32-bit bus addresses and 40-bit physical addresses.
package apt_pkg;
    localparam int BUS_W   = 32;
    localparam int PA_W    = 40;
    localparam int PG_SH   = 12;
    localparam int ENT_W   = 32;
    localparam int BASE_W  = 15;
    localparam int BASE_SH = 25;
    localparam int ORD_W   = 3;
    localparam int PIDX_W  = BUS_W - PG_SH;

    typedef enum logic [1:0] {
        ST_PASS  = 2'd0,
        ST_XLAT  = 2'd1,
        ST_FAULT = 2'd2
    } apt_status_e;

    typedef struct packed {
        apt_status_e          status;
        logic [PA_W-1:0]      paddr;
    } apt_result_t;

    // Turn a table entry plus page offset into a lookup result.
    function automatic apt_result_t apt_decode(input logic [ENT_W-1:0] ent,
                                               input logic [PG_SH-1:0] ofs);
        apt_result_t r;
        if (ent[0]) begin
            r.status = ST_XLAT;
            r.paddr  = {ent[11:4], ent[31:12], ofs};
        end else begin
            r.status = ST_FAULT;
            r.paddr  = '0;
        end
        return r;
    endfunction
endpackage

// File: rtl/apt_cfg_regs.sv
// Configuration registers and window bounds.
// Holds the base field, the enable bit and the size order, and works out the
// window's low and high bounds. It also works out whether the window is usable:
// the window is off when it would reach 0xFFFFFFFF or when its size is zero.
module apt_cfg_regs
    import apt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                base_we,
    input  logic [BASE_W-1:0]   base_in,
    input  logic                ctrl_we,
    input  logic [ORD_W:0]      ctrl_in,
    output logic                ap_on,
    output logic [BUS_W-1:0]    ap_lo,
    output logic [BUS_W-1:0]    ap_hi
);
    localparam int LIM_W = BASE_W + BASE_SH + 1;
    localparam logic [LIM_W-1:0] CEIL = LIM_W'(33'h0_FFFF_FFFF);

    logic [BASE_W-1:0] base_q;
    logic              en_q;
    logic [ORD_W-1:0]  ord_q;
    logic [LIM_W-1:0]  base_w, size_w, lim_w;
    logic              unused_base_hi;

    // Register the programmed fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            en_q   <= 1'b0;
            ord_q  <= '0;
        end else begin
            if (base_we) base_q <= base_in;
            if (ctrl_we) begin
                en_q  <= ctrl_in[0];
                ord_q <= ctrl_in[ORD_W:1];
            end
        end
    end

    // Derive the bounds and the usable flag.
    always_comb begin
        base_w = LIM_W'(base_q) << BASE_SH;
        size_w = (LIM_W'(1) << BASE_SH) << ord_q;
        lim_w  = base_w + size_w;
        ap_on  = en_q && (size_w != '0) && (lim_w < CEIL);
        ap_lo  = base_w[BUS_W-1:0];
        ap_hi  = lim_w[BUS_W-1:0];
    end

    assign unused_base_hi = ^base_w[LIM_W-1:BUS_W];
endmodule

// File: rtl/apt_entry_table.sv
// Internal table of translation entries.
// One write port and one synchronous read port. A read issued on one edge
// gives its data after that edge. A write and a read to the same slot on the
// same edge return the old value.
module apt_entry_table #(
    parameter int DEPTH = 64,
    parameter int ENT_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ENT_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ENT_W-1:0]  rd_data
);
    logic [ENT_W-1:0] mem [DEPTH];

    // Storage update and registered read.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
        if (rd_en) rd_data <= mem[rd_idx];
    end
endmodule

// File: rtl/apt_xlate_cache.sv
// One-entry translation cache with deferred flush.
// A flush while idle clears the entry at once. A flush while busy is held as
// pending and is applied on the cycle the in-flight lookup completes, after
// any fill from that lookup.
module apt_xlate_cache #(
    parameter int TAG_W = 20,
    parameter int ENT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              idle,
    input  logic              done_now,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [ENT_W-1:0]  fill_ent,
    output logic              vld,
    output logic [TAG_W-1:0]  tag,
    output logic [ENT_W-1:0]  ent
);
    logic pend_q;
    logic kill;

    assign kill = done_now && (pend_q || flush);

    // Track a flush that arrived during a lookup.
    always_ff @(posedge clk) begin
        if (!rst_n)                pend_q <= 1'b0;
        else if (done_now)         pend_q <= 1'b0;
        else if (flush && !idle)   pend_q <= 1'b1;
    end

    // Valid bit: flush or deferred flush wins over a fill.
    always_ff @(posedge clk) begin
        if (!rst_n)                vld <= 1'b0;
        else if (flush && idle)    vld <= 1'b0;
        else if (kill)             vld <= 1'b0;
        else if (fill_en)          vld <= 1'b1;
    end

    // Tag and entry payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag <= '0;
            ent <= '0;
        end else if (fill_en) begin
            tag <= fill_tag;
            ent <= fill_ent;
        end
    end
endmodule

// File: rtl/apt_translator.sv
// Aperture remapping address translator, top level.
// Accepts one lookup at a time. It captures the address, classifies it
// against the window, and then answers from the cache or reads the table.
// Assumes the configuration and the table are stable while a lookup is in flight.
module apt_translator
    import apt_pkg::*;
#(
    parameter int TBL_DEPTH = 64,
    localparam int IDX_W = $clog2(TBL_DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_base_we,
    input  logic [BASE_W-1:0]   cfg_base,
    input  logic                cfg_ctrl_we,
    input  logic [ORD_W:0]      cfg_ctrl,
    input  logic                tbl_we,
    input  logic [IDX_W-1:0]    tbl_idx,
    input  logic [ENT_W-1:0]    tbl_wdata,
    input  logic                flush,
    input  logic                lk_req,
    input  logic [BUS_W-1:0]    lk_addr,
    output logic                lk_ready,
    output logic                lk_done,
    output logic [1:0]          lk_status,
    output logic [PA_W-1:0]     lk_paddr
);
    typedef enum logic [1:0] {S_IDLE, S_CHECK, S_READ} state_e;

    state_e             st;
    logic [BUS_W-1:0]   addr_q;
    logic               ap_on;
    logic [BUS_W-1:0]   ap_lo, ap_hi;
    logic [BUS_W-1:0]   off;
    logic [PIDX_W-1:0]  pidx;
    logic               in_ap, in_tbl, hit;
    logic               rd_en, done_now, fill_en;
    logic [ENT_W-1:0]   mem_q;
    logic               c_vld;
    logic [PIDX_W-1:0]  c_tag;
    logic [ENT_W-1:0]   c_ent;
    apt_result_t        res_hit, res_mem;

    apt_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n),
        .base_we(cfg_base_we), .base_in(cfg_base),
        .ctrl_we(cfg_ctrl_we), .ctrl_in(cfg_ctrl),
        .ap_on(ap_on), .ap_lo(ap_lo), .ap_hi(ap_hi)
    );

    apt_entry_table #(.DEPTH(TBL_DEPTH), .ENT_W(ENT_W)) u_tbl (
        .clk(clk),
        .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_data(tbl_wdata),
        .rd_en(rd_en), .rd_idx(pidx[IDX_W-1:0]), .rd_data(mem_q)
    );

    apt_xlate_cache #(.TAG_W(PIDX_W), .ENT_W(ENT_W)) u_cache (
        .clk(clk), .rst_n(rst_n),
        .flush(flush), .idle(st == S_IDLE), .done_now(done_now),
        .fill_en(fill_en), .fill_tag(pidx), .fill_ent(mem_q),
        .vld(c_vld), .tag(c_tag), .ent(c_ent)
    );

    // Classify the captured address against the window and the cache.
    always_comb begin
        off      = addr_q - ap_lo;
        pidx     = off[BUS_W-1:PG_SH];
        in_ap    = ap_on && (addr_q >= ap_lo) && (addr_q < ap_hi);
        in_tbl   = pidx < PIDX_W'(TBL_DEPTH);
        hit      = c_vld && (c_tag == pidx);
        res_hit  = apt_decode(c_ent, off[PG_SH-1:0]);
        res_mem  = apt_decode(mem_q, off[PG_SH-1:0]);
        rd_en    = (st == S_CHECK) && in_ap && in_tbl && !hit;
        fill_en  = (st == S_READ);
        done_now = (st == S_READ) ||
                   ((st == S_CHECK) && !(in_ap && in_tbl && !hit));
    end

    // Lookup sequencer and registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            addr_q    <= '0;
            lk_done   <= 1'b0;
            lk_status <= ST_PASS;
            lk_paddr  <= '0;
        end else begin
            lk_done <= 1'b0;
            unique case (st)
                S_IDLE: begin
                    if (lk_req) begin
                        addr_q <= lk_addr;
                        st     <= S_CHECK;
                    end
                end
                S_CHECK: begin
                    if (!in_ap) begin
                        lk_done   <= 1'b1;
                        lk_status <= ST_PASS;
                        lk_paddr  <= PA_W'(addr_q);
                        st        <= S_IDLE;
                    end else if (!in_tbl) begin
                        lk_done   <= 1'b1;
                        lk_status <= ST_FAULT;
                        lk_paddr  <= '0;
                        st        <= S_IDLE;
                    end else if (hit) begin
                        lk_done   <= 1'b1;
                        lk_status <= res_hit.status;
                        lk_paddr  <= res_hit.paddr;
                        st        <= S_IDLE;
                    end else begin
                        st        <= S_READ;
                    end
                end
                S_READ: begin
                    lk_done   <= 1'b1;
                    lk_status <= res_mem.status;
                    lk_paddr  <= res_mem.paddr;
                    st        <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign lk_ready = (st == S_IDLE);
endmodule

// File: rtl/apt_translator_chk.sv
// Cycle-level properties of the translator, bound to the top module.
module apt_translator_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        lk_req,
    input logic        lk_ready,
    input logic        lk_done,
    input logic [1:0]  lk_status,
    input logic [39:0] lk_paddr,
    input logic        flush,
    input logic [31:0] addr_q,
    input logic        cache_vld
);
    p_status_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done |-> lk_status != 2'd3);

    p_fault_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && lk_status == 2'd2) |-> lk_paddr == 40'd0);

    p_pass_ident_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && lk_status == 2'd0) |-> lk_paddr == {8'd0, addr_q});

    p_offset_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && lk_status == 2'd1) |-> lk_paddr[11:0] == addr_q[11:0]);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done |=> !lk_done);

    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_ready && lk_req) |=> !lk_ready);

    p_flush_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && lk_ready) |=> !cache_vld);
endmodule

bind apt_translator apt_translator_chk u_chk (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_ready(lk_ready),
    .lk_done(lk_done), .lk_status(lk_status), .lk_paddr(lk_paddr),
    .flush(flush), .addr_q(addr_q), .cache_vld(c_vld)
);

// File: tb/apt_translator_bench.sv
module apt_translator_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;
    // {bus address, status, physical address, cycles from accept to done}
    localparam logic [77:0] VEC [NVEC] = '{
        {32'h0400_0ABC, 2'd1, 40'h12_3456_7ABC, 4'd2},
        {32'h0400_0FFF, 2'd1, 40'h12_3456_7FFF, 4'd1},
        {32'h0400_2010, 2'd1, 40'h0F_ABCD_E010, 4'd2},
        {32'h0400_1004, 2'd2, 40'h00_0000_0000, 4'd2},
        {32'h0400_1008, 2'd2, 40'h00_0000_0000, 4'd1},
        {32'h03FF_FFFF, 2'd0, 40'h00_03FF_FFFF, 4'd1},
        {32'h0600_0000, 2'd0, 40'h00_0600_0000, 4'd1},
        {32'h0403_F123, 2'd1, 40'hFF_0000_1123, 4'd2},
        {32'h0404_0000, 2'd2, 40'h00_0000_0000, 4'd1},
        {32'h0403_F456, 2'd1, 40'hFF_0000_1456, 4'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_base_we = 1'b0;
    logic [14:0] cfg_base = '0;
    logic        cfg_ctrl_we = 1'b0;
    logic [3:0]  cfg_ctrl = '0;
    logic        tbl_we = 1'b0;
    logic [5:0]  tbl_idx = '0;
    logic [31:0] tbl_wdata = '0;
    logic        flush = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_ready, lk_done;
    logic [1:0]  lk_status;
    logic [39:0] lk_paddr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    apt_translator u_apt_translator (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_base(input logic [14:0] b);
        @(negedge clk); cfg_base_we = 1'b1; cfg_base = b;
        @(negedge clk); cfg_base_we = 1'b0;
    endtask

    task automatic set_ctrl(input logic [2:0] ord, input logic en);
        @(negedge clk); cfg_ctrl_we = 1'b1; cfg_ctrl = {ord, en};
        @(negedge clk); cfg_ctrl_we = 1'b0;
    endtask

    task automatic put_entry(input logic [5:0] i, input logic [31:0] e);
        @(negedge clk); tbl_we = 1'b1; tbl_idx = i; tbl_wdata = e;
        @(negedge clk); tbl_we = 1'b0;
    endtask

    task automatic pulse_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] a, output logic [1:0] s,
                          output logic [39:0] pa, output int lat);
        @(negedge clk); lk_req = 1'b1; lk_addr = a;
        @(posedge clk);
        @(negedge clk); lk_req = 1'b0; lat = 0;
        while (!lk_done && lat < 8) begin
            @(posedge clk); lat++;
            @(negedge clk);
        end
        s = lk_status; pa = lk_paddr;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [1:0]  s;
        logic [39:0] pa;
        int          lat;
        int          seen;

        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", 64'(lk_ready), 64'd1);
        chk("R1 done after reset", 64'(lk_done), 64'd0);

        put_entry(6'd0,  32'h3456_7123);
        put_entry(6'd1,  32'h0000_0000);
        put_entry(6'd2,  32'hABCD_E0F3);
        put_entry(6'd63, 32'h0000_1FF3);
        set_base(15'd2);
        set_ctrl(3'd0, 1'b1);

        // Table of vectors: R5 decode, R6 faults, R3 bounds, R7 latency, R1 empty cache
        for (int v = 0; v < NVEC; v++) begin
            lookup(VEC[v][77:46], s, pa, lat);
            chk($sformatf("R5 vec%0d status", v), 64'(s), 64'(VEC[v][45:44]));
            chk($sformatf("R5 vec%0d paddr", v), 64'(pa), 64'(VEC[v][43:4]));
            chk($sformatf("R7 vec%0d latency", v), 64'(lat), 64'(VEC[v][3:0]));
        end

        // R8: stale cached entry survives a table rewrite until a flush
        lookup(32'h0400_2000, s, pa, lat);
        chk("R8 first fill", 64'(pa), 64'h0F_ABCD_E000);
        put_entry(6'd2, 32'h1111_1013);
        lookup(32'h0400_2004, s, pa, lat);
        chk("R8 stale paddr", 64'(pa), 64'h0F_ABCD_E004);
        chk("R8 stale hit latency", 64'(lat), 64'd1);
        pulse_flush();
        lookup(32'h0400_2008, s, pa, lat);
        chk("R9 idle flush miss latency", 64'(lat), 64'd2);
        chk("R9 fresh paddr", 64'(pa), 64'h01_1111_1008);

        // R9/R10: flush and a second request during an in-flight hit
        @(negedge clk); lk_req = 1'b1; lk_addr = 32'h0400_200C;
        @(posedge clk);
        @(negedge clk); lk_req = 1'b1; lk_addr = 32'h0400_0000; flush = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R9 in-flight hit done", 64'(lk_done), 64'd1);
        chk("R9 in-flight hit paddr", 64'(lk_paddr), 64'h01_1111_100C);
        lk_req = 1'b0; flush = 1'b0;
        seen = 0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            if (lk_done) seen++;
        end
        chk("R10 busy request ignored", 64'(seen), 64'd0);
        lookup(32'h0400_2010, s, pa, lat);
        chk("R9 deferred flush applied", 64'(lat), 64'd2);
        chk("R9 after flush paddr", 64'(pa), 64'h01_1111_1010);

        // R9: flush during a table read is deferred past the fill
        @(negedge clk); lk_req = 1'b1; lk_addr = 32'h0400_0020;
        @(posedge clk);
        @(negedge clk); lk_req = 1'b0; flush = 1'b1;
        @(posedge clk);
        @(negedge clk); flush = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R9 read completes", 64'(lk_done), 64'd1);
        chk("R9 read paddr", 64'(lk_paddr), 64'h12_3456_7020);
        lookup(32'h0400_0024, s, pa, lat);
        chk("R9 fill dropped by pending flush", 64'(lat), 64'd2);

        // R3: translation disabled
        set_ctrl(3'd0, 1'b0);
        lookup(32'h0400_0ABC, s, pa, lat);
        chk("R3 disabled status", 64'(s), 64'd0);
        chk("R3 disabled paddr", 64'(pa), 64'h00_0400_0ABC);

        // R4: window reaching the top of the 32-bit space is off
        set_base(15'h7F);
        set_ctrl(3'd0, 1'b1);
        lookup(32'hFE00_1000, s, pa, lat);
        chk("R4 overflow pass status", 64'(s), 64'd0);
        chk("R4 overflow pass paddr", 64'(pa), 64'h00_FE00_1000);
        set_base(15'h7E);
        lookup(32'hFC00_0ABC, s, pa, lat);
        chk("R4 just-fits status", 64'(s), 64'd1);
        chk("R4 just-fits paddr", 64'(pa), 64'h12_3456_7ABC);
        set_ctrl(3'd1, 1'b1);
        lookup(32'hFC00_0ABC, s, pa, lat);
        chk("R4 larger order overflows", 64'(s), 64'd0);

        // R2: base 128 MB, order 1 gives 64 MB
        set_base(15'd4);
        set_ctrl(3'd1, 1'b1);
        lookup(32'h0BFF_FFFF, s, pa, lat);
        chk("R2 last byte in window faults (beyond table)", 64'(s), 64'd2);
        lookup(32'h0C00_0000, s, pa, lat);
        chk("R2 limit passes", 64'(s), 64'd0);
        lookup(32'h0800_2000, s, pa, lat);
        chk("R2 translated from new base", 64'(pa), 64'h01_1111_1000);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule